// File: doc/BRIEF.md
# Banked GPIO Unit with Per-Pad Function Multiplexing

This block is a memory-mapped GPIO unit for 52 pads. A plain 32-bit register bus (address, write strobe, write data, registered read data) reaches a set of direction and data registers, split into a lower bank (pads 0–31) and an upper bank (pads 32–51). Each pad can also be handed to an alternate peripheral. That happens through a per-pad LED route, a per-pad alternate-mode bit and, for the upper bank, an inverted-sense wireless-function control bit. Base-mode bits claim whole fixed groups of pads at once.

For every pad, a priority selector picks one source: a base-mode group, the LED route, the alternate function, or plain GPIO. The chosen value and output enable are registered onto the pad. The peripherals connect through the `led_val`, `alt_val`/`alt_en` and `grp_val`/`grp_en` vectors. Software reads the pad level back through the data registers. An input pad returns its level through a two-stage synchronizer. An output pad returns its stored data bit.

Top module: `pad_mux_unit`

## Requirements
- R1: Banked addressing. Pads 0–31 use direction at 0x04 and data at 0x0C. Pads 32–51 use direction at 0x00 and data at 0x08. A pad's bit position is its number modulo 32, so the upper bank sits 4 bytes below the lower bank.
- R2: A GPIO-mode pad drives `pad_oe` equal to its direction bit (1 = output) and `pad_out` equal to its data bit.
- R3: A data-register read returns the stored data bit for output pads. For input pads it returns `pad_in` after two synchronizer flops.
- R4: The LED route register (0x10) is bit-per-pad for pads 0–23. A set bit drives that pad with `led_val` and output enable 1. Bits 24–31 have no effect and read 0.
- R5: The mode register (0x18) covers pads 0–31. Bit = 1 hands the pad to `alt_val`/`alt_en`, and bit = 0 leaves it as GPIO.
- R6: The control register (0x1C) covers pads 32–51 at bits 0–19 with inverted sense. Bit = 0 hands the pad to `alt_val`/`alt_en`, and bit = 1 leaves it as GPIO.
- R7: The base-mode register (0x38) claims groups that are then driven by `grp_val`/`grp_en`. The groups are:
  - bit 5: pads 8–9
  - bits 6, 7, 8, 9: pads 10–11, 12–13, 24–25, 26–27 respectively
  - bit 2: pads 2–7 and 24–31
  - bit 4: pad 35

  Pads 24–27 are claimed when either of their two bits is set.
- R8: Per-pad priority is base-mode group, then LED route, then mode/control alternate, then GPIO.
- R9: Synchronous reset clears direction, data, LED, mode and base-mode, and sets control bits 0–19. Every pad then leaves reset as a GPIO input with `pad_oe` = 0.
- R10: `bus_rdata` is registered one cycle after the address. Unimplemented bits read 0 (base-mode keeps only bits 2, 4–9), and unmapped addresses read 0.
- R11: `pad_out`/`pad_oe` are registered. A register write at edge k shows on the pads after edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte address of the register |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pad_in | input | 52 | Pad input levels (asynchronous) |
| led_val | input | 24 | LED function output per pad 0–23 |
| alt_val | input | 52 | Alternate-function output value per pad |
| alt_en | input | 52 | Alternate-function output enable per pad |
| grp_val | input | 52 | Group-function output value per pad |
| grp_en | input | 52 | Group-function output enable per pad |
| pad_out | output | 52 | Registered pad output value |
| pad_oe | output | 52 | Registered pad output enable |

## Verification
Most register faults in this block show up on the pads rather than on the bus. The bench therefore configures registers and then reads each pad's source from `pad_oe`/`pad_out` two cycles after the write. A wrong select bit or a misdecoded bank address shows up there as a pad driven by the wrong source. The four sources are given distinct oe/out encodings, so a priority inversion is visible at the same cycle. A synchronizer or read-mux fault shows up on `bus_rdata` one cycle after the read address. Input level changes appear after the third edge.

// File: rtl/pmx_pkg.sv
package pmx_pkg;
  localparam int unsigned BANK_W = 32;

  localparam logic [7:0] A_DIR_HI = 8'h00;
  localparam logic [7:0] A_DIR_LO = 8'h04;
  localparam logic [7:0] A_DAT_HI = 8'h08;
  localparam logic [7:0] A_DAT_LO = 8'h0C;
  localparam logic [7:0] A_LED    = 8'h10;
  localparam logic [7:0] A_MODE   = 8'h18;
  localparam logic [7:0] A_CTRL   = 8'h1C;
  localparam logic [7:0] A_BASE   = 8'h38;

  // implemented base-mode bits: 2, 4, 5, 6, 7, 8, 9
  localparam logic [31:0] BASE_IMPL = 32'h0000_03F4;

  typedef enum logic [1:0] {SRC_GPIO, SRC_ALT, SRC_LED, SRC_GRP} pad_src_e;

  // does base-mode word b claim pad p for its group function
  function automatic logic grp_hit(int unsigned p, logic [31:0] b);
    logic hit;
    hit = 1'b0;
    if (b[2] && ((p >= 2 && p <= 7) || (p >= 24 && p <= 31))) hit = 1'b1;
    if (b[4] && p == 35)                hit = 1'b1;
    if (b[5] && (p == 8  || p == 9))    hit = 1'b1;
    if (b[6] && (p == 10 || p == 11))   hit = 1'b1;
    if (b[7] && (p == 12 || p == 13))   hit = 1'b1;
    if (b[8] && (p == 24 || p == 25))   hit = 1'b1;
    if (b[9] && (p == 26 || p == 27))   hit = 1'b1;
    return hit;
  endfunction
endpackage

// File: rtl/pmx_sync.sv
module pmx_sync #(
  parameter int unsigned W      = 52,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '0;
    else     stg[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[s] <= '0;
      else     stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/pmx_regs.sv
module pmx_regs
  import pmx_pkg::*;
#(
  parameter int unsigned NUM_PADS = 52,
  parameter int unsigned LED_PADS = 24,
  localparam int unsigned HI_PADS = NUM_PADS - BANK_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [7:0]          addr,
  input  logic                we,
  input  logic [31:0]         wdata,
  output logic [31:0]         rdata,
  input  logic [NUM_PADS-1:0] pad_sync,
  output logic [NUM_PADS-1:0] dir_q,
  output logic [NUM_PADS-1:0] dat_q,
  output logic [LED_PADS-1:0] led_q,
  output logic [BANK_W-1:0]   mode_q,
  output logic [HI_PADS-1:0]  ctrl_q,
  output logic [31:0]         base_q
);
  logic [NUM_PADS-1:0] dat_view;
  logic [31:0]         rd_nxt;
  logic                mapped;

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q  <= '0;
      dat_q  <= '0;
      led_q  <= '0;
      mode_q <= '0;
      ctrl_q <= '1;
      base_q <= '0;
    end else if (we) begin
      case (addr)
        A_DIR_LO: dir_q[BANK_W-1:0]        <= wdata;
        A_DIR_HI: dir_q[NUM_PADS-1:BANK_W] <= wdata[HI_PADS-1:0];
        A_DAT_LO: dat_q[BANK_W-1:0]        <= wdata;
        A_DAT_HI: dat_q[NUM_PADS-1:BANK_W] <= wdata[HI_PADS-1:0];
        A_LED:    led_q  <= wdata[LED_PADS-1:0];
        A_MODE:   mode_q <= wdata;
        A_CTRL:   ctrl_q <= wdata[HI_PADS-1:0];
        A_BASE:   base_q <= wdata & BASE_IMPL;
        default: ;
      endcase
    end
  end

  // outputs read back their stored bit, inputs their synchronized level
  assign dat_view = (dir_q & dat_q) | (~dir_q & pad_sync);

  always_comb begin
    rd_nxt = '0;
    mapped = 1'b1;
    case (addr)
      A_DIR_LO: rd_nxt = dir_q[BANK_W-1:0];
      A_DIR_HI: rd_nxt = 32'(dir_q[NUM_PADS-1:BANK_W]);
      A_DAT_LO: rd_nxt = dat_view[BANK_W-1:0];
      A_DAT_HI: rd_nxt = 32'(dat_view[NUM_PADS-1:BANK_W]);
      A_LED:    rd_nxt = 32'(led_q);
      A_MODE:   rd_nxt = mode_q;
      A_CTRL:   rd_nxt = 32'(ctrl_q);
      A_BASE:   rd_nxt = base_q;
      default:  mapped = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_nxt;
  end

  p_rd_unmapped_r10: assert property (@(posedge clk) disable iff (rst)
    !mapped |=> rdata == '0);
  p_base_unimpl_r10: assert property (@(posedge clk) disable iff (rst)
    (we && addr == A_BASE) |=> (base_q & ~BASE_IMPL) == '0);
endmodule

// File: rtl/pmx_pad_sel.sv
module pmx_pad_sel
  import pmx_pkg::*;
#(
  parameter int unsigned NUM_PADS = 52,
  parameter int unsigned LED_PADS = 24,
  localparam int unsigned HI_PADS = NUM_PADS - BANK_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PADS-1:0] dir_q,
  input  logic [NUM_PADS-1:0] dat_q,
  input  logic [LED_PADS-1:0] led_q,
  input  logic [BANK_W-1:0]   mode_q,
  input  logic [HI_PADS-1:0]  ctrl_q,
  input  logic [31:0]         base_q,
  input  logic [LED_PADS-1:0] led_val,
  input  logic [NUM_PADS-1:0] alt_val,
  input  logic [NUM_PADS-1:0] alt_en,
  input  logic [NUM_PADS-1:0] grp_val,
  input  logic [NUM_PADS-1:0] grp_en,
  output logic [NUM_PADS-1:0] pad_out,
  output logic [NUM_PADS-1:0] pad_oe
);
  logic [NUM_PADS-1:0] sel_grp, sel_led, sel_alt, sel_gpio;
  logic [NUM_PADS-1:0] led_ext;
  logic [NUM_PADS-1:0] nxt_out, nxt_oe;

  for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
    logic     want_led, want_alt;
    pad_src_e src;

    if (p < LED_PADS) begin : g_led
      assign want_led   = led_q[p];
      assign led_ext[p] = led_val[p];
    end else begin : g_noled
      assign want_led   = 1'b0;
      assign led_ext[p] = 1'b0;
    end

    if (p < BANK_W) begin : g_lo
      assign want_alt = mode_q[p];
    end else begin : g_hi
      assign want_alt = ~ctrl_q[p-BANK_W];
    end

    assign src = grp_hit(p, base_q) ? SRC_GRP :
                 want_led           ? SRC_LED :
                 want_alt           ? SRC_ALT : SRC_GPIO;

    assign sel_grp[p]  = (src == SRC_GRP);
    assign sel_led[p]  = (src == SRC_LED);
    assign sel_alt[p]  = (src == SRC_ALT);
    assign sel_gpio[p] = (src == SRC_GPIO);

    assign nxt_out[p] = (src == SRC_GRP) ? grp_val[p] :
                        (src == SRC_LED) ? led_ext[p] :
                        (src == SRC_ALT) ? alt_val[p] : dat_q[p];
    assign nxt_oe[p]  = (src == SRC_GRP) ? grp_en[p]  :
                        (src == SRC_LED) ? 1'b1       :
                        (src == SRC_ALT) ? alt_en[p]  : dir_q[p];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pad_out <= '0;
      pad_oe  <= '0;
    end else begin
      pad_out <= nxt_out;
      pad_oe  <= nxt_oe;
    end
  end

  p_gpio_drive_r2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((((pad_oe ^ $past(dir_q)) | (pad_out ^ $past(dat_q))) & $past(sel_gpio)) == '0));
  p_group_take_r7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((((pad_oe ^ $past(grp_en)) | (pad_out ^ $past(grp_val))) & $past(sel_grp)) == '0));
  p_led_route_r4: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((((~pad_oe) | (pad_out ^ $past(led_ext))) & $past(sel_led)) == '0));
  p_alt_route_r5: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((((pad_oe ^ $past(alt_en)) | (pad_out ^ $past(alt_val))) & $past(sel_alt)) == '0));
endmodule

// File: rtl/pad_mux_unit.sv
module pad_mux_unit
  import pmx_pkg::*;
#(
  parameter int unsigned NUM_PADS    = 52,
  parameter int unsigned LED_PADS    = 24,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned HI_PADS    = NUM_PADS - BANK_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [7:0]          bus_addr,
  input  logic                bus_we,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  input  logic [NUM_PADS-1:0] pad_in,
  input  logic [LED_PADS-1:0] led_val,
  input  logic [NUM_PADS-1:0] alt_val,
  input  logic [NUM_PADS-1:0] alt_en,
  input  logic [NUM_PADS-1:0] grp_val,
  input  logic [NUM_PADS-1:0] grp_en,
  output logic [NUM_PADS-1:0] pad_out,
  output logic [NUM_PADS-1:0] pad_oe
);
  logic [NUM_PADS-1:0] pad_sync, dir_q, dat_q;
  logic [LED_PADS-1:0] led_q;
  logic [BANK_W-1:0]   mode_q;
  logic [HI_PADS-1:0]  ctrl_q;
  logic [31:0]         base_q;

  pmx_sync #(.W(NUM_PADS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(pad_in), .q(pad_sync)
  );

  pmx_regs #(.NUM_PADS(NUM_PADS), .LED_PADS(LED_PADS)) u_regs (
    .clk(clk), .rst(rst), .addr(bus_addr), .we(bus_we), .wdata(bus_wdata),
    .rdata(bus_rdata), .pad_sync(pad_sync), .dir_q(dir_q), .dat_q(dat_q),
    .led_q(led_q), .mode_q(mode_q), .ctrl_q(ctrl_q), .base_q(base_q)
  );

  pmx_pad_sel #(.NUM_PADS(NUM_PADS), .LED_PADS(LED_PADS)) u_sel (
    .clk(clk), .rst(rst), .dir_q(dir_q), .dat_q(dat_q), .led_q(led_q),
    .mode_q(mode_q), .ctrl_q(ctrl_q), .base_q(base_q), .led_val(led_val),
    .alt_val(alt_val), .alt_en(alt_en), .grp_val(grp_val), .grp_en(grp_en),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );
endmodule

// File: tb/test_pad_mux_unit.sv
module test_pad_mux_unit;
  localparam int CLK_NS = 10;
  localparam int NP = 52;
  localparam int NV = 23;

  // {addr, wdata, pad, {oe,out}}; sources: gpio out0 = 10, led = 11, alt = 01, group = 00
  localparam logic [49:0] VEC [NV] = '{
    {8'h04, 32'hFFFF_FFFF, 8'd5,  2'b10},  // R1 R2 lower dir
    {8'h00, 32'h000F_FFFF, 8'd40, 2'b10},  // R1 upper dir
    {8'h10, 32'h0000_0020, 8'd5,  2'b11},  // R4 led route
    {8'h18, 32'h0000_0020, 8'd5,  2'b11},  // R8 led over mode
    {8'h10, 32'h0000_0000, 8'd5,  2'b01},  // R5 mode alt
    {8'h38, 32'h0000_0004, 8'd5,  2'b00},  // R7 R8 flash group over mode
    {8'h38, 32'h0000_0004, 8'd30, 2'b00},  // R7 flash upper part
    {8'h38, 32'h0000_0100, 8'd5,  2'b01},  // R7 group released
    {8'h38, 32'h0000_0100, 8'd24, 2'b00},  // R7 overlap pair
    {8'h38, 32'h0000_0200, 8'd24, 2'b10},  // R7 pad 24 free
    {8'h38, 32'h0000_0200, 8'd27, 2'b00},  // R7 pair 26-27
    {8'h1C, 32'h000F_FFF7, 8'd35, 2'b01},  // R6 inverted ctrl
    {8'h38, 32'h0000_0010, 8'd35, 2'b00},  // R7 R8 pad 35 group
    {8'h38, 32'h0000_0000, 8'd35, 2'b01},  // R6
    {8'h1C, 32'h000F_FFFF, 8'd35, 2'b10},  // R6 back to gpio
    {8'h18, 32'h0000_0000, 8'd5,  2'b10},  // R5 mode cleared
    {8'h10, 32'hFF00_0000, 8'd24, 2'b10},  // R4 bits above 23 ignored
    {8'h38, 32'h0000_0020, 8'd9,  2'b00},  // R7 pair 8-9
    {8'h38, 32'h0000_0040, 8'd11, 2'b00},  // R7 pair 10-11
    {8'h38, 32'h0000_0080, 8'd12, 2'b00},  // R7 pair 12-13
    {8'h38, 32'h0000_0080, 8'd8,  2'b10},  // R7 pad 8 free
    {8'h18, 32'h0100_0000, 8'd24, 2'b01},  // R5 pad 24 alt
    {8'h10, 32'h0080_0000, 8'd23, 2'b11}   // R4 last led pad
  };

  logic clk = 1'b0, rst = 1'b1, bus_we = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [NP-1:0] pad_in = '0, alt_val = '1, alt_en = '0, grp_val = '0, grp_en = '0;
  logic [23:0] led_val = '1;
  logic [NP-1:0] pad_out, pad_oe;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  pad_mux_unit i_pad_mux_unit (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .led_val(led_val), .alt_val(alt_val), .alt_en(alt_en),
    .grp_val(grp_val), .grp_en(grp_en), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_we = 1'b0;
    @(negedge clk); d = bus_rdata;
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R9 reset state
    chk("R9 pad_oe after reset", 64'(pad_oe), 64'h0);
    rd(8'h1C, v); chk("R9 ctrl reset", 64'(v), 64'h000F_FFFF);
    rd(8'h04, v); chk("R9 dir reset", 64'(v), 64'h0);
    rd(8'h38, v); chk("R9 base reset", 64'(v), 64'h0);

    for (int i = 0; i < NV; i++) begin
      logic [7:0] pin;
      pin = VEC[i][9:2];
      wr(VEC[i][49:42], VEC[i][41:10]);
      @(negedge clk);
      chk($sformatf("R8 vector %0d pad %0d", i, pin),
          64'({pad_oe[pin], pad_out[pin]}), 64'(VEC[i][1:0]));
    end

    // R10 unimplemented bits and unmapped addresses
    wr(8'h38, 32'hFFFF_FFFF);
    rd(8'h38, v); chk("R10 base implemented bits", 64'(v), 64'h0000_03F4);
    wr(8'h38, 32'h0);
    rd(8'h00, v); chk("R10 upper dir unused bits", 64'(v), 64'h000F_FFFF);
    rd(8'h10, v); chk("R10 led upper bits", 64'(v), 64'h0080_0000);
    rd(8'h14, v); chk("R10 unmapped 0x14", 64'(v), 64'h0);
    rd(8'h3C, v); chk("R10 unmapped 0x3C", 64'(v), 64'h0);
    wr(8'h10, 32'h0);
    wr(8'h18, 32'h0);

    // R3 data readback: pads 32-35 outputs, 36-51 inputs
    wr(8'h00, 32'h0000_000F);
    wr(8'h08, 32'h000F_FFFF);
    pad_in = '0;
    repeat (4) @(negedge clk);
    rd(8'h08, v); chk("R3 inputs low, outputs stored", 64'(v), 64'h0000_000F);
    pad_in = '1;
    @(negedge clk); @(negedge clk);
    rd(8'h08, v); chk("R3 inputs high", 64'(v), 64'h000F_FFFF);
    wr(8'h08, 32'h0);
    rd(8'h08, v); chk("R3 output bits cleared", 64'(v), 64'h000F_FFF0);

    // R1 R11 lower data and register latency
    @(negedge clk); bus_addr = 8'h0C; bus_wdata = 32'h0000_0003; bus_we = 1'b1;
    @(posedge clk); #1;
    chk("R11 pad 1 before pad register", 64'(pad_out[1]), 64'h0);
    @(negedge clk); bus_we = 1'b0;
    @(posedge clk); #1;
    chk("R11 pad 1 one edge later", 64'(pad_out[1]), 64'h1);
    chk("R1 pad 32 untouched by lower data", 64'(pad_out[32]), 64'h0);
    wr(8'h08, 32'h0000_0001);
    @(negedge clk);
    chk("R1 R2 pad 32 upper data", 64'({pad_oe[32], pad_out[32]}), 64'h3);

    // R9 reset mid-run
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
    chk("R9 pad_oe after second reset", 64'(pad_oe), 64'h0);
    chk("R9 pad_out after second reset", 64'(pad_out), 64'h0);
    rd(8'h1C, v); chk("R9 ctrl after second reset", 64'(v), 64'h000F_FFFF);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_NS * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule